// File: doc/BRIEF.md
# Descriptor-Driven ADC Conversion Sequencer

This block runs a 16-input, 12-bit analog-to-digital converter from a queue of conversion descriptors. Software loads 8-bit descriptors into a list queue. Each descriptor names the input channel, the gain code, unipolar or bipolar range, and single-ended or differential wiring. When a trigger arrives, the sequencer takes the descriptor at the head of the queue. It drives the selects to the converter, pulses a start strobe, waits for the converter's done signal, and stores the 12-bit result in a sample queue.

Four small word registers sit on a simple bus:

| Address | Register | Access |
|---|---|---|
| 0 | Trigger and mode control | read / write |
| 1 | Queue enables | read / write |
| 2 | Status | read; a write clears the error flag |
| 3 | Data | a write pushes a descriptor; a read pops a sample |

The trigger source is one of three: a bus read of address 0, a scan tick, or an edge on an external trigger pin. In looping mode a used descriptor goes back to the tail of the list, so one list can drive conversions without end.

Top module: `adc_seq`

## Requirements
- R1: After reset, all registers read zero except the status register, which reads 0x0004 (sample queue empty). `cv_start` is low.
- R2: The descriptor fields map onto the converter selects as follows. Bits 3:0 go to `cv_chan`, bits 5:4 to `cv_gain`, bit 6 to `cv_unipolar` and bit 7 to `cv_diff`. Each conversion's `cv_data` is stored as one sample.
- R3: Control register bits 1:0 select the trigger mode: 0 disabled, 1 software, 2 scan, 3 external. In mode 1, each bus read of address 0 starts exactly one conversion, with a `cv_start` pulse one cycle wide. Data reads pop the samples in conversion order, zero-extended to 16 bits.
- R4: In mode 0, reads of address 0, scan ticks and external edges start no conversion.
- R5: In mode 3, a rising edge of `ext_trig` starts a conversion. When control bit 3 is set, a falling edge does so instead, and the other edge does nothing.
- R6: In mode 2, a one-cycle pulse on `scan_tick` starts one conversion.
- R7: When control bit 2 is clear, each conversion removes its descriptor from the list. When bit 2 is set, the descriptor is appended again at the tail, so the list repeats in order.
- R8: A descriptor with bit 7 set and either a channel above 7 or bit 6 set is invalid. When an invalid descriptor is taken, the sequencer consumes it without a conversion and sets status bit 5. A write to address 2 clears status bit 5.
- R9: The sample queue holds 16 entries. Status bit 3 is set at 8 or more entries and status bit 4 at 16. A result that arrives while the queue is full is dropped, and the stored samples are kept.
- R10: Enable register bit 10 enables the sample queue and bit 9 the list. While either bit is clear, its queue is empty and ignores pushes. Status bit 1 shows a full list of 16 entries.
- R11: A trigger that arrives while a conversion is running (status bit 0 set), or while the list is empty, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (reads at 0 and 3 have side effects) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| ext_trig | input | 1 | External trigger level |
| scan_tick | input | 1 | Scan trigger pulse |
| cv_start | output | 1 | Conversion start pulse |
| cv_chan | output | 4 | Input channel select |
| cv_gain | output | 2 | Gain code |
| cv_unipolar | output | 1 | Unipolar range select |
| cv_diff | output | 1 | Differential wiring select |
| cv_done | input | 1 | Converter result valid |
| cv_data | input | 12 | Converter result |

## Verification
The embedded properties check the following on every cycle:
- `cv_start` is one cycle wide.
- No start is ever issued for an invalid differential descriptor.
- A conversion stays busy until the converter reports done.
- Both queue counts stay within their depths.
- A disabled sample queue is empty.

Only the directed scenarios can show the rest:
- the descriptor-to-select mapping and result ordering;
- the edge polarity of the external trigger;
- the looping order of the list;
- the half-full and full thresholds, and that the seventeenth result is dropped;
- that triggers are ignored while busy or in mode 0.

// File: rtl/adc_seq.sv
module adc_seq #(
  parameter int LIST_DEPTH = 16,
  parameter int SAMP_DEPTH = 16,
  parameter int SAMP_W     = 12,
  parameter int HALF_MARK  = SAMP_DEPTH / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  input  logic              ext_trig,
  input  logic              scan_tick,
  output logic              cv_start,
  output logic [3:0]        cv_chan,
  output logic [1:0]        cv_gain,
  output logic              cv_unipolar,
  output logic              cv_diff,
  input  logic              cv_done,
  input  logic [SAMP_W-1:0] cv_data
);
  localparam int LAW = $clog2(LIST_DEPTH);
  localparam int SAW = $clog2(SAMP_DEPTH);

  logic [5:0] ctrl;
  logic en_samp, en_list, err, busy, ext_q;
  logic [7:0] cur;

  logic [7:0]        lmem [LIST_DEPTH];
  logic [LAW-1:0]    lhead, ltail;
  logic [LAW:0]      lcnt;
  logic [SAMP_W-1:0] smem [SAMP_DEPTH];
  logic [SAW-1:0]    shead, stail;
  logic [SAW:0]      scnt;

  wire unused_wbits = ^{bus_wdata[15:11], bus_wdata[8:6]};

  wire at_ctl  = bus_addr == 2'd0;
  wire at_en   = bus_addr == 2'd1;
  wire at_stat = bus_addr == 2'd2;
  wire at_data = bus_addr == 2'd3;

  wire ext_edge = ctrl[3] ? (ext_q & ~ext_trig) : (~ext_q & ext_trig);
  wire trig = !busy && (
                (ctrl[1:0] == 2'd1 && bus_rd && at_ctl) ||
                (ctrl[1:0] == 2'd2 && scan_tick) ||
                (ctrl[1:0] == 2'd3 && ext_edge));
  wire [7:0] desc = lmem[lhead];
  wire fire    = trig && en_list && lcnt != 0;
  wire bad     = desc[7] && (desc[3] || desc[6]);
  wire recycle = fire && ctrl[2];
  wire lpush   = bus_wr && at_data && en_list && !recycle && lcnt != (LAW+1)'(LIST_DEPTH);
  wire spush   = busy && cv_done && en_samp && scnt != (SAW+1)'(SAMP_DEPTH);
  wire spop    = bus_rd && at_data && en_samp && scnt != 0;

  assign {cv_diff, cv_unipolar, cv_gain, cv_chan} = cur;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0; en_samp <= 1'b0; en_list <= 1'b0; ext_q <= 1'b0;
    end else begin
      ext_q <= ext_trig;
      if (bus_wr && at_ctl) ctrl <= bus_wdata[5:0];
      if (bus_wr && at_en) {en_samp, en_list} <= bus_wdata[10:9];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; cv_start <= 1'b0; cur <= '0; err <= 1'b0;
    end else begin
      cv_start <= 1'b0;
      if (fire && !bad) begin
        busy <= 1'b1; cv_start <= 1'b1; cur <= desc;
      end else if (busy && cv_done) begin
        busy <= 1'b0;
      end
      if (fire && bad) err <= 1'b1;
      else if (bus_wr && at_stat) err <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en_list) begin
      lhead <= '0; ltail <= '0; lcnt <= '0;
    end else begin
      if (fire) lhead <= (lhead == LAW'(LIST_DEPTH-1)) ? '0 : lhead + 1'b1;
      if (recycle || lpush) ltail <= (ltail == LAW'(LIST_DEPTH-1)) ? '0 : ltail + 1'b1;
      lcnt <= lcnt + (LAW+1)'(recycle || lpush) - (LAW+1)'(fire);
    end
  end

  always_ff @(posedge clk) begin
    if (recycle) lmem[ltail] <= desc;
    else if (lpush) lmem[ltail] <= bus_wdata[7:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en_samp) begin
      shead <= '0; stail <= '0; scnt <= '0;
    end else begin
      if (spop) shead <= (shead == SAW'(SAMP_DEPTH-1)) ? '0 : shead + 1'b1;
      if (spush) stail <= (stail == SAW'(SAMP_DEPTH-1)) ? '0 : stail + 1'b1;
      scnt <= scnt + (SAW+1)'(spush) - (SAW+1)'(spop);
    end
  end

  always_ff @(posedge clk) if (spush) smem[stail] <= cv_data;

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = {10'b0, ctrl};
      2'd1:    bus_rdata = {5'b0, en_samp, en_list, 9'b0};
      2'd2:    bus_rdata = {10'b0, err, scnt == (SAW+1)'(SAMP_DEPTH),
                            scnt >= (SAW+1)'(HALF_MARK), scnt == 0,
                            lcnt == (LAW+1)'(LIST_DEPTH), busy};
      default: bus_rdata = (scnt != 0) ? 16'(smem[shead]) : 16'h0;
    endcase
  end

  assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cv_start |=> !cv_start);
  assert_no_bad_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cv_start |-> !(cv_diff && (cv_chan[3] || cv_unipolar)));
  assert_busy_until_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cv_done) |=> busy);
  assert_samp_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    scnt <= (SAW+1)'(SAMP_DEPTH));
  assert_list_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lcnt <= (LAW+1)'(LIST_DEPTH));
  assert_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en_samp |=> scnt == 0);
endmodule

// File: tb/test_adc_seq.sv
module test_adc_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [1:0] bus_addr = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic ext_trig = 0, scan_tick = 0;
  logic cv_start, cv_unipolar, cv_diff;
  logic [3:0] cv_chan;
  logic [1:0] cv_gain;
  logic cv_done = 0;
  logic [11:0] cv_data;

  int total = 0, fails = 0, starts = 0, cdly = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_seq i_adc_seq (.clk, .rst_n, .bus_addr, .bus_wr, .bus_rd, .bus_wdata, .bus_rdata,
    .ext_trig, .scan_tick, .cv_start, .cv_chan, .cv_gain, .cv_unipolar, .cv_diff,
    .cv_done, .cv_data);

  assign cv_data = {cv_chan, cv_gain, cv_unipolar, cv_diff, 4'h5};

  always @(posedge clk) begin
    cv_done <= 1'b0;
    if (cv_start) begin cdly <= 3; starts <= starts + 1; end
    else if (cdly > 0) begin cdly <= cdly - 1; if (cdly == 1) cv_done <= 1'b1; end
  end

  function automatic logic [15:0] expv(input logic [7:0] d);
    return {4'h0, d[3:0], d[5:4], d[6], d[7], 4'h5};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic trig_sw();
    logic [15:0] t;
    rd(2'd0, t); idle(10);
  endtask

  task automatic flush();
    wr(2'd1, 16'h0000); wr(2'd1, 16'h0600);
  endtask

  localparam logic [7:0] VEC [6] = '{8'h00, 8'h1F, 8'h2A, 8'h3B, 8'h47, 8'h85};

  initial begin
    #(CLK_PERIOD * 150000);
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int s0;
    idle(3); rst_n = 1; idle(1);
    rd(2'd2, v); chk("R1 status", v, 16'h0004);
    rd(2'd0, v); chk("R1 ctrl", v, 16'h0000);
    rd(2'd1, v); chk("R1 enables", v, 16'h0000);
    chk("R1 cv_start", {15'b0, cv_start}, 16'h0);

    wr(2'd1, 16'h0600); wr(2'd0, 16'h0001);
    foreach (VEC[i]) begin
      wr(2'd3, {8'h0, VEC[i]});
      s0 = starts; trig_sw();
      chk("R3 one start", 16'(starts - s0), 16'd1);
      rd(2'd3, v); chk("R2 sample", v, expv(VEC[i]));
      rd(2'd2, v); chk("R3 empty after pop", v, 16'h0004);
    end

    wr(2'd0, 16'h0000); wr(2'd3, 16'h0001);
    s0 = starts; trig_sw();
    chk("R4 disabled no start", 16'(starts - s0), 16'd0);
    rd(2'd2, v); chk("R4 no sample", v, 16'h0004);
    flush(); wr(2'd0, 16'h0001); s0 = starts; trig_sw();
    chk("R10 flushed list no start", 16'(starts - s0), 16'd0);

    wr(2'd3, 16'h0088); s0 = starts; trig_sw();
    chk("R8 diff ch8 no start", 16'(starts - s0), 16'd0);
    rd(2'd2, v); chk("R8 error flag", v, 16'h0024);
    wr(2'd2, 16'h0000); rd(2'd2, v); chk("R8 error cleared", v, 16'h0004);
    wr(2'd3, 16'h00C1); trig_sw();
    rd(2'd2, v); chk("R8 diff unipolar flagged", v, 16'h0024);
    wr(2'd2, 16'h0000);
    wr(2'd3, 16'h0083); trig_sw();
    rd(2'd3, v); chk("R8 valid diff converts", v, expv(8'h83));

    wr(2'd0, 16'h0005); wr(2'd3, 16'h0012); wr(2'd3, 16'h0023);
    trig_sw(); trig_sw(); trig_sw();
    rd(2'd3, v); chk("R7 loop 1", v, expv(8'h12));
    rd(2'd3, v); chk("R7 loop 2", v, expv(8'h23));
    rd(2'd3, v); chk("R7 loop 3", v, expv(8'h12));
    flush();

    wr(2'd0, 16'h0001); wr(2'd3, 16'h0031); wr(2'd3, 16'h0032);
    s0 = starts;
    @(negedge clk); bus_addr = 0; bus_rd = 1;
    @(negedge clk); @(negedge clk); bus_rd = 0; idle(10);
    chk("R11 busy ignores", 16'(starts - s0), 16'd1);
    rd(2'd3, v); chk("R11 first sample", v, expv(8'h31));
    rd(2'd2, v); chk("R11 only one sample", v, 16'h0004);
    trig_sw(); rd(2'd3, v); chk("R11 second after idle", v, expv(8'h32));

    wr(2'd0, 16'h0003); wr(2'd3, 16'h0004);
    @(negedge clk); ext_trig = 1; idle(10);
    rd(2'd3, v); chk("R5 rising edge", v, expv(8'h04));
    wr(2'd3, 16'h0005); s0 = starts;
    @(negedge clk); ext_trig = 0; idle(10);
    chk("R5 falling ignored", 16'(starts - s0), 16'd0);
    wr(2'd0, 16'h000B);
    @(negedge clk); ext_trig = 1; idle(10);
    chk("R5 rising ignored in falling mode", 16'(starts - s0), 16'd0);
    @(negedge clk); ext_trig = 0; idle(10);
    rd(2'd3, v); chk("R5 falling edge", v, expv(8'h05));

    wr(2'd0, 16'h0002); wr(2'd3, 16'h0006);
    @(negedge clk); scan_tick = 1; @(negedge clk); scan_tick = 0; idle(10);
    rd(2'd3, v); chk("R6 scan tick", v, expv(8'h06));

    wr(2'd0, 16'h0005); wr(2'd3, 16'h0001); wr(2'd3, 16'h0002);
    for (int k = 1; k <= 17; k++) begin
      trig_sw();
      if (k == 7)  begin rd(2'd2, v); chk("R9 below half", v & 16'h0008, 16'h0000); end
      if (k == 8)  begin rd(2'd2, v); chk("R9 half", v & 16'h0008, 16'h0008); end
      if (k == 16) begin rd(2'd2, v); chk("R9 full", v & 16'h0010, 16'h0010); end
    end
    for (int k = 1; k <= 16; k++) begin
      rd(2'd3, v); chk("R9 kept order", v, expv((k % 2) ? 8'h01 : 8'h02));
    end
    rd(2'd2, v); chk("R9 extra dropped", v, 16'h0004);
    flush();

    wr(2'd0, 16'h0000);
    for (int k = 0; k < 16; k++) wr(2'd3, 16'(k));
    rd(2'd2, v); chk("R10 list full", v, 16'h0006);
    flush(); rd(2'd2, v); chk("R10 list flushed", v, 16'h0004);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule